// File: doc/BRIEF.md
# Multi-Size Page Translation Lookaside Buffer

This block is a small, fully associative translation cache. A lookup presents a virtual address with a write flag and a privilege flag. One clock later the block returns a response: whether any stored entry covers the address, the translated physical address, and whether the access breaks the entry's permissions. Four page sizes share the same entry pool: 1 MB, 64 KB, 4 KB and 1 KB. Each entry's stored size sets how many low address bits are left out of the tag match and pass through to the physical address untranslated. A single pool serves both instruction and data translations.

Entries are written through a refill port. In normal use a table walker drives that port, and here the bench drives it. A refill entry may be marked locked. Round-robin replacement then skips it, so it stays until invalidate-all clears it. Two commands remove entries. Invalidate-all clears the whole pool. Invalidate-by-address removes the entry that maps one virtual address. On 64 KB and 4 KB pages, each quarter of the page has its own permission field. Sections and 1 KB pages use a single field.

Top module: `tlb_multi_size`

## Requirements
- R1: Each cycle with `lk_valid_i` high produces exactly one cycle of `rsp_valid_o` on the next clock edge, carrying hit, address and fault for that request. With no request there is no response.
- R2: Size code `fill_size_i` 0 = 1 MB (tag bits 31:20), 1 = 64 KB (31:16), 2 = 4 KB (31:12), 3 = 1 KB (31:10). On a hit, the physical address takes the entry's frame bits above the page offset and the request's own bits below it.
- R3: `fill_ap_i` holds four 2-bit fields, with field q at bits [2q+1:2q]. A 64 KB page uses address bits 15:14 as q. A 4 KB page uses address bits 11:10 as q. Sections and 1 KB pages always use field 0.
- R4: Field code 0 faults on every access. Code 1 allows privileged accesses only. Code 2 allows privileged read and write, and user read only. Code 3 allows every access. A fault is only reported together with a hit.
- R5: On a miss, the response has hit 0, address 0 and fault 0.
- R6: Refill writes the first unlocked entry at or after a round-robin pointer. The pointer then moves to the entry after the one written. Reset and invalidate-all return the pointer to entry 0.
- R7: Refill never overwrites a locked entry. When every entry is locked, a refill is dropped.
- R8: Invalidate-all removes every entry, locked ones included, and clears their locks.
- R9: Invalidate-by-address removes any unlocked entry that maps the given address. With `PROTECT_LOCKED` set (the default), a locked entry that matches is kept.
- R10: Commands in the same cycle are ranked invalidate-all, then invalidate-by-address, then refill. Only the highest-ranked command acts, and the others in that cycle are dropped.
- R11: A lookup in the same cycle as an update is answered from the contents before that update.
- R12: After reset the pool is empty, every lookup misses, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_write_i | input | 1 | Lookup is a write |
| lk_priv_i | input | 1 | Lookup is privileged |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_hit_o | output | 1 | An entry matched |
| rsp_pa_o | output | PA_W | Translated physical address, 0 on a miss |
| rsp_fault_o | output | 1 | Permission fault on a hit |
| fill_valid_i | input | 1 | Refill strobe |
| fill_va_i | input | VA_W | Virtual base of the refilled page |
| fill_pa_i | input | PA_W | Physical base of the refilled page |
| fill_size_i | input | 2 | Page size code |
| fill_ap_i | input | 8 | Four 2-bit permission fields |
| fill_lock_i | input | 1 | Lock the new entry |
| inv_all_i | input | 1 | Invalidate every entry |
| inv_va_valid_i | input | 1 | Invalidate-by-address strobe |
| inv_va_i | input | VA_W | Address for invalidate-by-address |

## Verification
The single-match check assumes that no two live entries ever map the same address. Overlapping refills are outside the block's contract. The bench keeps its mappings in disjoint address ranges, and where it reuses a range it clears the pool with invalidate-all first. The lock-retention check assumes locks are only removed by an invalidate command. The refill port offers no other way to remove a lock, so every stimulus keeps to this assumption.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int MIN_OFF = 10;
  localparam int MAX_OFF = 20;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    AP_NONE    = 2'd0,
    AP_PRIV    = 2'd1,
    AP_USER_RO = 2'd2,
    AP_FULL    = 2'd3
  } ap_e;

  function automatic int off_bits(pg_size_e s);
    case (s)
      PG_SECTION: return 20;
      PG_LARGE:   return 16;
      PG_SMALL:   return 12;
      default:    return 10;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
#(
  parameter int VA_W = 32,
  localparam int TAG_W = VA_W - MIN_OFF
) (
  input  logic             valid_i,
  input  pg_size_e         size_i,
  input  logic [TAG_W-1:0] vtag_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             hit_o
);
  logic [TAG_W-1:0] keep;

  always_comb begin
    for (int b = 0; b < TAG_W; b++) keep[b] = (b + MIN_OFF) >= off_bits(size_i);
    hit_o = valid_i && (((va_i[VA_W-1:MIN_OFF] ^ vtag_i) & keep) == '0);
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  pg_size_e   size_i,
  input  logic [7:0] ap_i,
  input  logic [1:0] q_large_i,
  input  logic [1:0] q_small_i,
  input  logic       write_i,
  input  logic       priv_i,
  output logic       fault_o
);
  logic [1:0] q;
  ap_e        fld;

  always_comb begin
    case (size_i)
      PG_LARGE: q = q_large_i;
      PG_SMALL: q = q_small_i;
      default:  q = 2'd0;
    endcase
    fld = ap_e'(ap_i[2*q +: 2]);
    case (fld)
      AP_NONE:    fault_o = 1'b1;
      AP_PRIV:    fault_o = !priv_i;
      AP_USER_RO: fault_o = !priv_i && write_i;
      default:    fault_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [N-1:0]     locked_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             found_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int idx;
    found_o  = 1'b0;
    victim_o = '0;
    // downward scan: the nearest unlocked slot after ptr wins
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(ptr_q) + k) % N;
      if (!locked_i[idx]) begin
        found_o  = 1'b1;
        victim_o = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= '0;
    else if (clear_i)           ptr_q <= '0;
    else if (take_i && found_o) ptr_q <= (int'(victim_o) == N - 1) ? '0 : victim_o + 1'b1;
  end
endmodule

// File: rtl/tlb_multi_size.sv
module tlb_multi_size
  import tlb_pkg::*;
#(
  parameter int VA_W           = 32,
  parameter int PA_W           = 32,
  parameter int NUM_ENTRIES    = 8,
  parameter bit PROTECT_LOCKED = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lk_valid_i,
  input  logic [VA_W-1:0] lk_va_i,
  input  logic            lk_write_i,
  input  logic            lk_priv_i,
  output logic            rsp_valid_o,
  output logic            rsp_hit_o,
  output logic [PA_W-1:0] rsp_pa_o,
  output logic            rsp_fault_o,
  input  logic            fill_valid_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [PA_W-1:0] fill_pa_i,
  input  logic [1:0]      fill_size_i,
  input  logic [7:0]      fill_ap_i,
  input  logic            fill_lock_i,
  input  logic            inv_all_i,
  input  logic            inv_va_valid_i,
  input  logic [VA_W-1:0] inv_va_i
);
  localparam int TAG_W = VA_W - MIN_OFF;
  localparam int FRM_W = PA_W - MIN_OFF;
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] valid_q, locked_q, hit_vec, inv_vec;
  pg_size_e               size_q  [NUM_ENTRIES];
  logic [TAG_W-1:0]       vtag_q  [NUM_ENTRIES];
  logic [FRM_W-1:0]       frame_q [NUM_ENTRIES];
  logic [7:0]             ap_q    [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    tlb_entry_match #(.VA_W(VA_W)) lk_match_i (
      .valid_i(valid_q[g]), .size_i(size_q[g]), .vtag_i(vtag_q[g]),
      .va_i(lk_va_i), .hit_o(hit_vec[g])
    );
    tlb_entry_match #(.VA_W(VA_W)) inv_match_i (
      .valid_i(valid_q[g]), .size_i(size_q[g]), .vtag_i(vtag_q[g]),
      .va_i(inv_va_i), .hit_o(inv_vec[g])
    );
  end

  // one-hot select of the matching entry
  logic [1:0]       sel_size_raw;
  pg_size_e         sel_size;
  logic [FRM_W-1:0] sel_frame;
  logic [7:0]       sel_ap;
  logic             any_hit;

  always_comb begin
    sel_size_raw = '0;
    sel_frame    = '0;
    sel_ap       = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i]) begin
        sel_size_raw |= size_q[i];
        sel_frame    |= frame_q[i];
        sel_ap       |= ap_q[i];
      end
    end
    sel_size = pg_size_e'(sel_size_raw);
    any_hit  = |hit_vec;
  end

  logic [PA_W-1:0] pa_c;
  always_comb begin
    int off;
    off = off_bits(sel_size);
    pa_c[MIN_OFF-1:0] = lk_va_i[MIN_OFF-1:0];
    for (int b = MIN_OFF; b < MAX_OFF; b++)
      pa_c[b] = (b < off) ? lk_va_i[b] : sel_frame[b-MIN_OFF];
    pa_c[PA_W-1:MAX_OFF] = sel_frame[FRM_W-1:MAX_OFF-MIN_OFF];
  end

  logic perm_fault;
  tlb_perm_check perm_i (
    .size_i(sel_size), .ap_i(sel_ap),
    .q_large_i(lk_va_i[15:14]), .q_small_i(lk_va_i[11:10]),
    .write_i(lk_write_i), .priv_i(lk_priv_i), .fault_o(perm_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_fault_o <= 1'b0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i && any_hit;
      rsp_pa_o    <= (lk_valid_i && any_hit) ? pa_c : '0;
      rsp_fault_o <= lk_valid_i && any_hit && perm_fault;
    end
  end

  // replacement
  logic [IDX_W-1:0] victim;
  logic             victim_ok, fill_take;

  assign fill_take = fill_valid_i && !inv_all_i && !inv_va_valid_i;

  tlb_rr_victim #(.N(NUM_ENTRIES)) victim_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(inv_all_i),
    .locked_i(locked_q), .take_i(fill_take),
    .victim_o(victim), .found_o(victim_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      locked_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        size_q[i]  <= PG_SECTION;
        vtag_q[i]  <= '0;
        frame_q[i] <= '0;
        ap_q[i]    <= '0;
      end
    end else if (inv_all_i) begin
      valid_q  <= '0;
      locked_q <= '0;
    end else if (inv_va_valid_i) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (inv_vec[i] && !(PROTECT_LOCKED && locked_q[i])) begin
          valid_q[i]  <= 1'b0;
          locked_q[i] <= 1'b0;
        end
      end
    end else if (fill_valid_i && victim_ok) begin
      valid_q[victim]  <= 1'b1;
      locked_q[victim] <= fill_lock_i;
      size_q[victim]   <= pg_size_e'(fill_size_i);
      vtag_q[victim]   <= fill_va_i[VA_W-1:MIN_OFF];
      frame_q[victim]  <= fill_pa_i[PA_W-1:MIN_OFF];
      ap_q[victim]     <= fill_ap_i;
    end
  end
endmodule

// File: rtl/tlb_multi_size_chk.sv
module tlb_multi_size_chk #(
  parameter int PA_W        = 32,
  parameter int NUM_ENTRIES = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lk_valid_i,
  input logic                   rsp_valid_o,
  input logic                   rsp_hit_o,
  input logic [PA_W-1:0]        rsp_pa_o,
  input logic                   rsp_fault_o,
  input logic                   inv_all_i,
  input logic                   inv_va_valid_i,
  input logic [NUM_ENTRIES-1:0] valid_q,
  input logic [NUM_ENTRIES-1:0] locked_q,
  input logic [NUM_ENTRIES-1:0] hit_vec
);
  assert_rsp_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);
  assert_single_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_fault_on_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_hit_o && rsp_valid_o);
  assert_miss_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_pa_o == '0) && !rsp_fault_o);
  assert_lock_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inv_all_i && !inv_va_valid_i) |=>
      ((valid_q & locked_q & $past(valid_q & locked_q)) == $past(valid_q & locked_q)));
  assert_inv_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (valid_q == '0) && (locked_q == '0));
endmodule

bind tlb_multi_size tlb_multi_size_chk #(.PA_W(PA_W), .NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_pa_o(rsp_pa_o),
  .rsp_fault_o(rsp_fault_o), .inv_all_i(inv_all_i), .inv_va_valid_i(inv_va_valid_i),
  .valid_q(valid_q), .locked_q(locked_q), .hit_vec(hit_vec)
);

// File: tb/tlb_multi_size_tb_top.sv
module tlb_multi_size_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0, lk_priv = 0;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_pa;
  logic        fill_valid = 0, fill_lock = 0;
  logic [31:0] fill_va = '0, fill_pa = '0;
  logic [1:0]  fill_size = '0;
  logic [7:0]  fill_ap = '0;
  logic        inv_all = 0, inv_va_valid = 0;
  logic [31:0] inv_va = '0;

  int n_chk = 0, n_bad = 0;

  tlb_multi_size dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_write_i(lk_write), .lk_priv_i(lk_priv),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault),
    .fill_valid_i(fill_valid), .fill_va_i(fill_va), .fill_pa_i(fill_pa),
    .fill_size_i(fill_size), .fill_ap_i(fill_ap), .fill_lock_i(fill_lock),
    .inv_all_i(inv_all), .inv_va_valid_i(inv_va_valid), .inv_va_i(inv_va)
  );

  // {va, write, priv, exp_hit, exp_pa, exp_fault}
  localparam int NV = 20;
  localparam logic [67:0] VEC [NV] = '{
    {32'h1234_5678, 1'b0, 1'b0, 1'b1, 32'h8004_5678, 1'b0},
    {32'h123F_FFFC, 1'b1, 1'b0, 1'b1, 32'h800F_FFFC, 1'b1},
    {32'h1230_0000, 1'b1, 1'b1, 1'b1, 32'h8000_0000, 1'b0},
    {32'h1240_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
    {32'h4001_0010, 1'b0, 1'b1, 1'b1, 32'h9005_0010, 1'b1},
    {32'h4001_4020, 1'b1, 1'b1, 1'b1, 32'h9005_4020, 1'b0},
    {32'h4001_7FFF, 1'b0, 1'b0, 1'b1, 32'h9005_7FFF, 1'b1},
    {32'h4001_8000, 1'b0, 1'b0, 1'b1, 32'h9005_8000, 1'b0},
    {32'h4001_BFF0, 1'b1, 1'b0, 1'b1, 32'h9005_BFF0, 1'b1},
    {32'h4001_C004, 1'b1, 1'b0, 1'b1, 32'h9005_C004, 1'b0},
    {32'h4001_9000, 1'b1, 1'b1, 1'b1, 32'h9005_9000, 1'b0},
    {32'h4002_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
    {32'h5000_3004, 1'b0, 1'b1, 1'b1, 32'hA000_7004, 1'b1},
    {32'h5000_3404, 1'b0, 1'b1, 1'b1, 32'hA000_7404, 1'b0},
    {32'h5000_3800, 1'b1, 1'b0, 1'b1, 32'hA000_7800, 1'b1},
    {32'h5000_3FFC, 1'b1, 1'b0, 1'b1, 32'hA000_7FFC, 1'b0},
    {32'h5000_4000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
    {32'h6000_07FF, 1'b1, 1'b0, 1'b1, 32'hB000_0FFF, 1'b0},
    {32'h6000_0800, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
    {32'h6000_03FF, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic w, input logic p,
                        output logic v, output logic h, output logic [31:0] pa, output logic f);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_write = w; lk_priv = p;
    @(negedge clk);
    lk_valid = 0;
    v = rsp_valid; h = rsp_hit; pa = rsp_pa; f = rsp_fault;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input logic [7:0] ap, input logic lk);
    @(negedge clk);
    fill_valid = 1; fill_va = va; fill_pa = pa; fill_size = sz; fill_ap = ap; fill_lock = lk;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_inv_all();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  task automatic do_inv_va(input logic [31:0] va);
    @(negedge clk); inv_va_valid = 1; inv_va = va;
    @(negedge clk); inv_va_valid = 0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input logic exp_h);
    logic v, h, f;
    logic [31:0] pa;
    lookup(va, 1'b0, 1'b1, v, h, pa, f);
    chk(req, {31'd0, h}, {31'd0, exp_h});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic v, h, f;
    logic [31:0] pa;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 no response idle", {31'd0, rsp_valid}, 32'd0);
    lookup(32'h1234_5678, 1'b0, 1'b1, v, h, pa, f);
    chk("R12 empty miss", {31'd0, h}, 32'd0);
    chk("R1 response strobe", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R1 single-cycle response", {31'd0, rsp_valid}, 32'd0);

    // reference mappings for R2/R3/R4/R5
    fill(32'h1230_0000, 32'h8000_0000, 2'd0, 8'hFE, 1'b0);
    fill(32'h4001_0000, 32'h9005_0000, 2'd1, 8'hE4, 1'b0);
    fill(32'h5000_3000, 32'hA000_7000, 2'd2, 8'hE4, 1'b0);
    fill(32'h6000_0400, 32'hB000_0C00, 2'd3, 8'h03, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [67:0] e;
      e = VEC[i];
      lookup(e[67:36], e[35], e[34], v, h, pa, f);
      chk($sformatf("R2 hit vec%0d", i), {31'd0, h}, {31'd0, e[33]});
      chk($sformatf("R2 R5 pa vec%0d", i), pa, e[32:1]);
      chk($sformatf("R3 R4 fault vec%0d", i), {31'd0, f}, {31'd0, e[0]});
    end

    // R6/R7: one locked entry then a full round of unlocked refills
    do_inv_all();
    fill(32'h7000_0000, 32'hC000_0000, 2'd0, 8'hFF, 1'b1);
    for (int i = 0; i < 8; i++)
      fill(32'h7100_0000 + i * 32'h1000, 32'hD000_0000 + i * 32'h1000, 2'd2, 8'hFF, 1'b0);
    expect_hit("R7 locked entry survives refill", 32'h7000_0004, 1'b1);
    expect_hit("R6 oldest unlocked evicted", 32'h7100_0000, 1'b0);
    for (int i = 1; i < 8; i++)
      expect_hit($sformatf("R6 entry %0d retained", i), 32'h7100_0000 + i * 32'h1000, 1'b1);

    // R9: invalidate by address
    do_inv_va(32'h7100_3ABC);
    expect_hit("R9 unlocked removed", 32'h7100_3000, 1'b0);
    expect_hit("R9 neighbour kept", 32'h7100_4000, 1'b1);
    do_inv_va(32'h7001_0000);
    expect_hit("R9 locked protected", 32'h7000_0000, 1'b1);

    // R8: invalidate all clears locked too
    do_inv_all();
    expect_hit("R8 locked cleared", 32'h7000_0000, 1'b0);
    expect_hit("R8 unlocked cleared", 32'h7100_4000, 1'b0);

    // R7: all entries locked drops further refill
    for (int i = 0; i < 8; i++)
      fill(32'h7200_0000 + i * 32'h1000, 32'hE000_0000 + i * 32'h1000, 2'd2, 8'hFF, 1'b1);
    fill(32'h7300_0000, 32'hF000_0000, 2'd2, 8'hFF, 1'b0);
    expect_hit("R7 refill dropped when full-locked", 32'h7300_0000, 1'b0);
    for (int i = 0; i < 8; i++)
      expect_hit($sformatf("R7 locked %0d kept", i), 32'h7200_0000 + i * 32'h1000, 1'b1);

    // R10: priority
    do_inv_all();
    @(negedge clk);
    inv_all = 1; fill_valid = 1; fill_va = 32'h7400_0000; fill_pa = 32'h1000_0000;
    fill_size = 2'd2; fill_ap = 8'hFF; fill_lock = 1'b0;
    @(negedge clk);
    inv_all = 0; fill_valid = 0;
    expect_hit("R10 inv_all beats refill", 32'h7400_0000, 1'b0);
    fill(32'h7500_0000, 32'h1100_0000, 2'd2, 8'hFF, 1'b0);
    @(negedge clk);
    inv_va_valid = 1; inv_va = 32'h7500_0000;
    fill_valid = 1; fill_va = 32'h7600_0000; fill_pa = 32'h1200_0000;
    @(negedge clk);
    inv_va_valid = 0; fill_valid = 0;
    expect_hit("R10 inv_va acts", 32'h7500_0000, 1'b0);
    expect_hit("R10 refill dropped under inv_va", 32'h7600_0000, 1'b0);

    // R11: lookup coincident with refill sees old contents
    @(negedge clk);
    fill_valid = 1; fill_va = 32'h7700_0000; fill_pa = 32'h1300_0000;
    fill_size = 2'd3; fill_ap = 8'h03; fill_lock = 1'b0;
    lk_valid = 1; lk_va = 32'h7700_0010; lk_write = 0; lk_priv = 1;
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    chk("R11 same-cycle lookup misses", {31'd0, rsp_hit}, 32'd0);
    lookup(32'h7700_0010, 1'b0, 1'b1, v, h, pa, f);
    chk("R11 following lookup hits", {31'd0, h}, 32'd1);
    chk("R2 tiny pa", pa, 32'h1300_0010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule